// File: doc/BRIEF.md
# NAND Host Register Interface

A memory-mapped register front end that lets software drive an 8-bit NAND flash device one bus cycle at a time. Command, address and write-data bytes written by software are tagged with their kind and queued in a small write buffer. A strobe engine takes entries from the buffer one at a time and plays them onto the flash pins. Command bytes go out with CLE high, address bytes with ALE high, and data bytes with neither. Each byte is written with a write-enable pulse whose width comes from a control register.

Reading is a two-step exchange. Software writes any value to the read-request register, which queues a read entry. When the engine reaches that entry it pulses read-enable and captures the flash data bus at the end of the pulse. It then places the byte in the read-data register and raises a read-ready interrupt flag, and software collects the byte once that flag is seen. Status bits show the buffer level and a synchronised copy of the flash ready/busy pin. Interrupt flags are cleared by writing ones to them. A self-clearing reset bit flushes the buffer and aborts the engine.

Top module: `nand_host_regs`

## Requirements
- R1: After reset, status (offset 1) reads 0x11 with the ready pin high, interrupt status (offset 2) reads 0x00, control (offset 0) reads 0x00 and the reset register (offset 3) reads 0x00.
- R2: A write to offset 4 queues a command byte. It produces exactly one write-enable low pulse with CLE high, ALE low and the written byte on the data-out pins.
- R3: A write to offset 5 queues an address byte. It produces one write-enable pulse with ALE high and CLE low, carrying the written byte.
- R4: A write to offset 6 queues a data byte. It produces one write-enable pulse with both CLE and ALE low, carrying the written byte.
- R5: Control bits [3:0] set the write delay and bits [7:4] set the read delay. A write-enable or read-enable pulse stays low for delay+1 clocks, and the two enables are never low together.
- R6: Any write to offset 7 produces one read-enable pulse and captures the input data bus on its last low clock. The byte then reads back from offset 8, and interrupt bit3 (read ready) is set.
- R7: The write buffer holds 4 entries and is drained in write order. Status bit1 is set while the buffer is full, and status bit4 is set while it is empty. Status bits 2 and 3 read 0.
- R8: A write to offsets 4 to 7 while the buffer is full is dropped and sets interrupt bit1 (overflow).
- R9: Interrupt bit2 is set on the clock where the buffer goes from full to not full.
- R10: Writing a 1 to an interrupt bit clears it, and writing a 0 leaves it unchanged. If a set event and a clear fall in the same clock, the flag stays set.
- R11: Status bit0 follows the ready/busy input through a two-flop synchroniser. A low-to-high transition of the synchronised value sets interrupt bit0, and a high-to-low transition does not.
- R12: Writing 1 to bit0 of offset 3 flushes the write buffer, ends any strobe in progress and blocks new transfers. The bit reads 1 for 4 clocks and then clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, registered one clock after the address |
| nand_rb | input | 1 | Flash ready (1) / busy (0) |
| nand_din | input | 8 | Flash data bus input |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dout | output | 8 | Flash data bus output |

## Verification
A hardware event that sets an interrupt flag can land in the same clock as a software write-one-to-clear of that flag. The bench provokes this by raising the ready/busy input on a known half cycle and timing the clear write so that it is sampled on the edge where the synchroniser's rising edge sets bit0. It then judges by reading back that the flag survived, and that a later clear alone removes it. A second collision is a burst of bus writes while the strobe engine is draining the buffer. Here pushes, pops and overflow drops interleave, and the recorded pin pulses must match exactly the accepted bytes, in order.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;
  // register offsets; 4..7 are buffered and their low two bits form the tag
  localparam logic [3:0] OFS_CTRL  = 4'd0;
  localparam logic [3:0] OFS_STAT  = 4'd1;
  localparam logic [3:0] OFS_IRQ   = 4'd2;
  localparam logic [3:0] OFS_RESET = 4'd3;
  localparam logic [3:0] OFS_RDAT  = 4'd8;

  typedef enum logic [1:0] {
    TAG_CMD  = 2'd0,
    TAG_ADDR = 2'd1,
    TAG_DATA = 2'd2,
    TAG_READ = 2'd3
  } wb_tag_t;

  typedef struct packed {
    wb_tag_t    tag;
    logic [7:0] byte_v;
  } wb_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REC  = 2'd2
  } strobe_st_t;
endpackage

// File: rtl/nand_wbuf.sv
module nand_wbuf
  import nand_host_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      push,
  input  wb_entry_t din,
  input  logic      pop,
  output wb_entry_t dout,
  output logic      full,
  output logic      empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wb_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  // storage without reset so it maps to a RAM primitive
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/nand_strobe.sv
module nand_strobe
  import nand_host_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic [DLY_W-1:0] rd_dly,
  input  logic             start,
  input  wb_entry_t        entry,
  input  logic [7:0]       nand_din,
  output logic             idle,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dout,
  output logic             rd_done,
  output logic [7:0]       rd_byte
);
  strobe_st_t       st;
  logic [DLY_W-1:0] cnt;
  logic             is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cnt <= '0; is_rd <= 1'b0;
      cle <= 1'b0; ale <= 1'b0; we_n <= 1'b1; re_n <= 1'b1;
      dout <= '0; rd_done <= 1'b0; rd_byte <= '0;
    end else begin
      rd_done <= 1'b0;
      if (abort) begin
        st <= ST_IDLE; cle <= 1'b0; ale <= 1'b0;
        we_n <= 1'b1; re_n <= 1'b1;
      end else begin
        case (st)
          ST_IDLE: if (start) begin
            is_rd <= (entry.tag == TAG_READ);
            cle   <= (entry.tag == TAG_CMD);
            ale   <= (entry.tag == TAG_ADDR);
            dout  <= entry.byte_v;
            we_n  <= (entry.tag == TAG_READ);
            re_n  <= (entry.tag != TAG_READ);
            cnt   <= (entry.tag == TAG_READ) ? rd_dly : wr_dly;
            st    <= ST_ACT;
          end
          ST_ACT: begin
            if (cnt == '0) begin
              we_n <= 1'b1;
              re_n <= 1'b1;
              if (is_rd) begin
                rd_byte <= nand_din;
                rd_done <= 1'b1;
              end
              st <= ST_REC;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: begin
            cle <= 1'b0;
            ale <= 1'b0;
            st  <= ST_IDLE;
          end
        endcase
      end
    end
  end

  assign idle = (st == ST_IDLE);
endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
  import nand_host_pkg::*;
#(
  parameter int WB_DEPTH   = 4,
  parameter int DLY_W      = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       nand_rb,
  input  logic [7:0] nand_din,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic       nand_re_n,
  output logic [7:0] nand_dout
);
  localparam int CTRL_W = 2 * DLY_W;
  localparam int RCNT_W = $clog2(RST_CYCLES + 1);
  localparam int IRQ_W  = 5;

  logic [CTRL_W-1:0] ctrl_q;
  logic [IRQ_W-1:0]  irq_q, irq_set, irq_clr;
  logic [7:0]        rd_q, rd_byte;
  logic [RCNT_W-1:0] rst_cnt;
  logic              rst_busy;
  logic              rb_s1, rb_s2, full_q;
  logic              is_buf, buf_wr, push, ovf_ev, pop, eng_idle, rd_done;
  logic              wb_full, wb_empty;
  wb_entry_t         wb_in, wb_out;

  assign is_buf = (bus_addr[3:2] == 2'b01);
  assign buf_wr = bus_we && is_buf;
  assign push   = buf_wr && !wb_full && !rst_busy;
  assign ovf_ev = buf_wr && wb_full;
  assign wb_in  = '{tag: wb_tag_t'(bus_addr[1:0]), byte_v: bus_wdata};
  assign pop    = !wb_empty && eng_idle && !rst_busy;

  nand_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst(rst), .flush(rst_busy), .push(push), .din(wb_in),
    .pop(pop), .dout(wb_out), .full(wb_full), .empty(wb_empty)
  );

  nand_strobe #(.DLY_W(DLY_W)) u_strobe (
    .clk(clk), .rst(rst), .abort(rst_busy),
    .wr_dly(ctrl_q[DLY_W-1:0]), .rd_dly(ctrl_q[CTRL_W-1:DLY_W]),
    .start(pop), .entry(wb_out), .nand_din(nand_din), .idle(eng_idle),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dout(nand_dout), .rd_done(rd_done), .rd_byte(rd_byte)
  );

  // interrupt events; a set in the same clock as a clear wins
  assign irq_set = {1'b0, rd_done, full_q && !wb_full, ovf_ev, rb_s1 && !rb_s2};
  assign irq_clr = (bus_we && bus_addr == OFS_IRQ) ? bus_wdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; irq_q <= '0; rd_q <= '0;
      rst_busy <= 1'b0; rst_cnt <= '0;
      rb_s1 <= 1'b1; rb_s2 <= 1'b1; full_q <= 1'b0;
    end else begin
      rb_s1  <= nand_rb;
      rb_s2  <= rb_s1;
      full_q <= wb_full;
      irq_q  <= (irq_q & ~irq_clr) | irq_set;
      if (rd_done) rd_q <= rd_byte;
      if (bus_we && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (rst_busy) begin
        if (rst_cnt == '0) rst_busy <= 1'b0;
        else               rst_cnt  <= rst_cnt - 1'b1;
      end else if (bus_we && bus_addr == OFS_RESET && bus_wdata[0]) begin
        rst_busy <= 1'b1;
        rst_cnt  <= RCNT_W'(RST_CYCLES - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata <= 8'(ctrl_q);
        OFS_STAT:  bus_rdata <= {3'b000, wb_empty, 2'b00, wb_full, rb_s2};
        OFS_IRQ:   bus_rdata <= 8'(irq_q);
        OFS_RESET: bus_rdata <= {7'b0, rst_busy};
        OFS_RDAT:  bus_rdata <= rd_q;
        default:   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/nand_host_chk.sv
module nand_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       wb_full,
  input logic       ovf_ev,
  input logic       rd_done,
  input logic       rb_s2,
  input logic       rst_busy,
  input logic [4:0] irq_q
);
  // R3
  latch_enables_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));
  // R5
  strobes_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> irq_q[1]);
  // R9
  full_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wb_full) |=> irq_q[2]);
  // R6
  read_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> irq_q[3]);
  // R11
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_s2) |-> irq_q[0]);
  // R12
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rst_busy |=> (nand_we_n && nand_re_n));
endmodule

bind nand_host_regs nand_host_chk u_chk (
  .clk(clk), .rst(rst), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .wb_full(wb_full),
  .ovf_ev(ovf_ev), .rd_done(rd_done), .rb_s2(rb_s2),
  .rst_busy(rst_busy), .irq_q(irq_q)
);

// File: tb/tb_nand_host_regs.sv
module tb_nand_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       nand_rb = 1'b1;
  logic [7:0] nand_din = '0;
  logic       nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0] nand_dout;

  int n_chk = 0;
  int n_bad = 0;

  // pulse monitor: kind 0 cmd, 1 addr, 2 data, 3 read
  int rec_k [256];
  int rec_b [256];
  int rec_w [256];
  int nrec = 0;
  int wcnt = 0, rcnt = 0, wk = 0, wb = 0;

  always #5 clk = ~clk;

  nand_host_regs dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nand_rb(nand_rb),
    .nand_din(nand_din), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dout(nand_dout)
  );

  always @(negedge clk) begin
    if (!nand_we_n) begin
      wcnt = wcnt + 1;
      wk = nand_cle ? 0 : (nand_ale ? 1 : 2);
      wb = int'(nand_dout);
    end else if (wcnt > 0) begin
      rec_k[nrec] = wk; rec_b[nrec] = wb; rec_w[nrec] = wcnt;
      nrec = nrec + 1; wcnt = 0;
    end
    if (!nand_re_n) begin
      rcnt = rcnt + 1;
    end else if (rcnt > 0) begin
      rec_k[nrec] = 3; rec_b[nrec] = 0; rec_w[nrec] = rcnt;
      nrec = nrec + 1; rcnt = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, base, exp_b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    rd(4'd1, v); chk("R1 status", v, 8'h11);
    rd(4'd2, v); chk("R1 irq", v, 8'h00);
    rd(4'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(4'd3, v); chk("R1 reset reg", v, 8'h00);

    // R2 R3 R4 R5 sweep kinds x write delays
    for (int t = 0; t < 3; t++) begin
      for (int d = 0; d < 16; d++) begin
        exp_b = ((t * 16 + d) * 7 + 3) & 8'hFF;
        wr(4'd0, 8'(d));
        base = nrec;
        wr(4'(4 + t), 8'(exp_b));
        idle(24);
        chk("R2/R3/R4 pulse count", nrec - base, 1);
        chk(t == 0 ? "R2 kind" : (t == 1 ? "R3 kind" : "R4 kind"), rec_k[base], t);
        chk("R2 byte", rec_b[base], exp_b);
        chk("R5 write width", rec_w[base], d + 1);
      end
    end

    // R6 R5 read sweep over read delays, R10 clear of bit3
    for (int d = 0; d < 16; d++) begin
      exp_b = (8'hA5 ^ (d * 17)) & 8'hFF;
      wr(4'd0, 8'(d << 4));
      nand_din = 8'(exp_b);
      base = nrec;
      wr(4'd7, 8'h00);
      v = 0;
      for (int p = 0; p < 40 && (v & 8) == 0; p++) rd(4'd2, v);
      chk("R6 ready flag", v & 8, 8);
      rd(4'd8, v); chk("R6 read byte", v, exp_b);
      chk("R6 kind", rec_k[base], 3);
      chk("R5 read width", rec_w[base], d + 1);
      wr(4'd2, 8'h08);
      rd(4'd2, v); chk("R10 clear bit3", v & 8, 0);
    end

    // R7 R8 R9 burst into a slow engine
    wr(4'd0, 8'h0F);
    base = nrec;
    for (int i = 0; i < 7; i++) begin
      bus_we = 1'b1; bus_addr = 4'd6; bus_wdata = 8'(8'h30 + i);
      @(negedge clk);
    end
    bus_we = 1'b0;
    rd(4'd1, v);
    chk("R7 full", v & 2, 2);
    chk("R7 empty low", v & 16, 0);
    chk("R7 page bits", v & 12, 0);
    rd(4'd2, v); chk("R8 overflow", v & 2, 2);
    chk("R9 not yet", v & 4, 0);
    idle(150);
    rd(4'd2, v); chk("R9 edge", v & 4, 4);
    rd(4'd1, v); chk("R7 empty", v, 8'h11);
    chk("R8 accepted count", nrec - base, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R7 order", rec_b[base + i], 8'h30 + i);
      chk("R5 width 16", rec_w[base + i], 16);
    end
    wr(4'd2, 8'h1F);
    rd(4'd2, v); chk("R10 clear all", v, 0);

    // R10 zeros leave flags
    wr(4'd6, 8'h55); wr(4'd6, 8'h56); wr(4'd6, 8'h57); wr(4'd6, 8'h58);
    wr(4'd6, 8'h59); wr(4'd6, 8'h5A);
    wr(4'd2, 8'h00);
    rd(4'd2, v); chk("R10 zero write", v & 2, 2);
    idle(150);
    wr(4'd2, 8'h1F);

    // R12 counter reset flushes buffer and aborts engine
    for (int i = 0; i < 4; i++) begin
      bus_we = 1'b1; bus_addr = 4'd6; bus_wdata = 8'(8'hC0 + i);
      @(negedge clk);
    end
    base = nrec;
    bus_we = 1'b1; bus_addr = 4'd3; bus_wdata = 8'h01;
    @(negedge clk);
    bus_we = 1'b0;
    rd(4'd3, v); chk("R12 busy readback", v, 1);
    idle(6);
    rd(4'd3, v); chk("R12 self clear", v, 0);
    rd(4'd1, v); chk("R12 buffer empty", v & 18, 16);
    idle(80);
    chk("R12 pulses after flush", nrec - base, 1);

    // R11 ready pin mirror and rising event
    wr(4'd2, 8'h1F);
    nand_rb = 1'b0;
    idle(4);
    rd(4'd1, v); chk("R11 busy mirror", v & 1, 0);
    rd(4'd2, v); chk("R11 no event on fall", v & 1, 0);
    nand_rb = 1'b1;
    idle(4);
    rd(4'd1, v); chk("R11 ready mirror", v & 1, 1);
    rd(4'd2, v); chk("R11 rise event", v & 1, 1);
    wr(4'd2, 8'h01);
    rd(4'd2, v); chk("R10 clear bit0", v & 1, 0);

    // R10 set and clear in the same clock
    nand_rb = 1'b0;
    idle(4);
    nand_rb = 1'b1;
    @(negedge clk);
    wr(4'd2, 8'h01);
    rd(4'd2, v); chk("R10 set wins", v & 1, 1);
    wr(4'd2, 8'h01);
    rd(4'd2, v); chk("R10 later clear", v & 1, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule